// File: doc/BRIEF.md
# Fixed-Coefficient Table Multiplier

This block multiplies an 8-bit unsigned operand by a coefficient that is fixed when the hardware is built. It uses no shift-add array. The operand is cut into a low 4-bit slice and a high 4-bit slice. Each slice selects one entry of its own 16-entry table of precomputed multiples of the coefficient. The high partial product is moved up four bit places, and one adder then combines it with the low partial product into a 16-bit result.

The tables are filled at elaboration from the `COEF` parameter, so no memory image is loaded. The datapath is a two-stage pipeline: one register stage after the table lookup and one after the add. The block accepts a new operand on every clock cycle. Each result comes out with its own valid flag, a fixed two cycles after its operand.

Top module: `kcm_mult`

## Requirements
- R1: For every operand value 0..255 presented with `in_valid` high, `out_prod` equals operand × `COEF` exactly.
- R2: Table entry i, for i in 0..15, holds i × `COEF`. An operand whose high slice `in_data[7:4]` is zero therefore yields i × `COEF` for a low slice of i.
- R3: The high slice `in_data[7:4]` contributes its table entry shifted left by four bits. An operand of i × 16 yields i × `COEF` × 16.
- R4: `out_valid` and `out_prod` for an operand appear exactly two clock edges after the edge that samples that operand with `in_valid` high.
- R5: Operands presented on consecutive cycles produce results on consecutive cycles, in the same order, with no gaps.
- R6: While no operand is being delivered, `out_valid` is low and `out_prod` keeps its last value.
- R7: A synchronous active-low reset clears `out_valid` and `out_prod` to 0 and discards operands already in the pipeline.
- R8: The result is correct at the coefficient extremes. With `COEF` = 0 every result is 0, and with `COEF` = 255 the largest result is 65025.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand on `in_data` is valid this cycle |
| in_data | input | 8 | Unsigned operand |
| out_valid | output | 1 | `out_prod` holds a new result |
| out_prod | output | 16 | Operand × `COEF` |

## Verification
Every result is due two rising edges after the edge that samples its operand. The bench drives each operand on a falling edge and reads the outputs on falling edges. A result is therefore read exactly two falling edges after its operand was driven, and the operand that the current output belongs to is taken from a two-deep record of the values driven earlier. Hold and reset behaviour are read on the falling edges between those two edges and after them, so a result that arrives a cycle early or late is seen as a mismatch.

// File: rtl/kcm_mult.sv
module kcm_mult #(
  parameter int unsigned COEF   = 183,
  parameter int          NIB_W  = 4,
  parameter int          COEF_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [2*NIB_W-1:0]          in_data,
  output logic                        out_valid,
  output logic [2*NIB_W+COEF_W-1:0]   out_prod
);
  localparam int IN_W  = 2 * NIB_W;
  localparam int PP_W  = NIB_W + COEF_W;
  localparam int OUT_W = IN_W + COEF_W;
  localparam int TBL_N = 1 << NIB_W;

  logic             pp_vld;
  logic [OUT_W-1:0] sum;

  for (genvar t = 0; t < 2; t++) begin : g_nib
    logic [PP_W-1:0] tab [TBL_N];
    logic [PP_W-1:0] pp_q;

    for (genvar i = 0; i < TBL_N; i++) begin : g_ent
      assign tab[i] = PP_W'(i * COEF);
    end

    always_ff @(posedge clk) begin
      if (!rst_n)        pp_q <= '0;
      else if (in_valid) pp_q <= tab[in_data[t*NIB_W +: NIB_W]];
    end
  end

  assign sum = {g_nib[1].pp_q, {NIB_W{1'b0}}} + {{NIB_W{1'b0}}, g_nib[0].pp_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pp_vld    <= 1'b0;
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else begin
      pp_vld    <= in_valid;
      out_valid <= pp_vld;
      if (pp_vld) out_prod <= sum;
    end
  end
endmodule

// File: rtl/kcm_mult_chk.sv
module kcm_mult_chk #(
  parameter int unsigned COEF   = 183,
  parameter int          NIB_W  = 4,
  parameter int          COEF_W = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic [2*NIB_W-1:0]        in_data,
  input logic                      out_valid,
  input logic [2*NIB_W+COEF_W-1:0] out_prod
);
  localparam int OUT_W = 2 * NIB_W + COEF_W;
  localparam logic [OUT_W-1:0] TOP = OUT_W'(((1 << (2 * NIB_W)) - 1) * COEF);

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)         age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  assert_reset_clears_R7: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_prod == '0));

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && $past(in_valid, 2)) |->
      (out_prod == OUT_W'($past(in_data, 2) * COEF)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && !$past(in_valid, 2)) |-> $stable(out_prod));

  assert_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_prod <= TOP));
endmodule

bind kcm_mult kcm_mult_chk #(.COEF(COEF), .NIB_W(NIB_W), .COEF_W(COEF_W)) u_chk (.*);

// File: tb/kcm_mult_test.sv
module kcm_mult_test;
  localparam int CLK_PERIOD = 10;
  localparam int K_MAIN = 183;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        v_m, v_z, v_x;
  logic [15:0] p_m, p_z, p_x;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kcm_mult #(.COEF(K_MAIN)) uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_data(in_data), .out_valid(v_m), .out_prod(p_m));
  kcm_mult #(.COEF(0)) uut_zero (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_data(in_data), .out_valid(v_z), .out_prod(p_z));
  kcm_mult #(.COEF(255)) uut_max (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_data(in_data), .out_valid(v_x), .out_prod(p_x));

  task automatic check(string req, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(string req, int x);
    check(req, {v_m, p_m}, {1'b1, 16'(x * K_MAIN)});
    check(req, {v_z, p_z}, {1'b1, 16'd0});
    check(req, {v_x, p_x}, {1'b1, 16'(x * 255)});
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    in_valid = 1'b1;
    in_data = 8'hff;
    repeat (3) @(negedge clk);
    check("R7 reset main", {v_m, p_m}, 17'd0);
    check("R7 reset kmax", {v_x, p_x}, 17'd0);
    rst_n = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 idle after reset", {v_m, p_m}, 17'd0);
  endtask

  task automatic test_sweep();
    int hist [2];
    for (int n = 0; n < 258; n++) begin
      @(negedge clk);
      if (n >= 2) check_all("R1 R5 R8 sweep", hist[0]);
      hist[0] = hist[1];
      hist[1] = n;
      in_valid = (n < 256);
      in_data = 8'(n);
    end
    @(negedge clk);
    check("R6 valid drops", {16'd0, v_m}, 17'd0);
  endtask

  task automatic test_slices();
    for (int i = 0; i < 16; i++) begin
      for (int s = 0; s < 2; s++) begin
        int x = (s == 0) ? i : i * 16;
        @(negedge clk);
        in_valid = 1'b1;
        in_data = 8'(x);
        @(negedge clk);
        in_valid = 1'b0;
        check("R4 not yet", {16'd0, v_m}, 17'd0);
        @(negedge clk);
        check_all(s == 0 ? "R2 low slice" : "R3 high slice", x);
      end
    end
  endtask

  task automatic test_hold();
    @(negedge clk);
    in_valid = 1'b1;
    in_data = 8'd200;
    @(negedge clk);
    in_valid = 1'b0;
    in_data = 8'd7;
    @(negedge clk);
    check_all("R4 R8 due", 200);
    for (int c = 0; c < 4; c++) begin
      in_data = 8'(c + 30);
      @(negedge clk);
      check("R6 hold main", {v_m, p_m}, {1'b0, 16'(200 * K_MAIN)});
      check("R6 hold kmax", {v_x, p_x}, {1'b0, 16'd51000});
    end
  endtask

  task automatic test_reset_flush();
    @(negedge clk);
    in_valid = 1'b1;
    in_data = 8'd99;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R7 flush", {v_m, p_m}, 17'd0);
    repeat (2) @(negedge clk);
    check("R7 flushed stays idle", {v_m, p_m}, 17'd0);
  endtask

  initial begin
    fork
      begin
        test_reset();
        test_sweep();
        test_slices();
        test_hold();
        test_reset_flush();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule